// File: doc/BRIEF.md
# Multi-core interrupt router with claim-on-read

This block takes a parameterised set of level-sensitive hardware interrupt lines and distributes them to several processor cores. Each core gets two outputs of its own: a normal interrupt line and a fast interrupt line. Software decides, separately for every source and every core, whether that source may interrupt that core. A class bit on each source selects which of the two lines it drives. A source can be routed to no core, to one core, or to several cores at the same time.

Each core has a claim strobe. A claim returns the lowest-numbered source that is enabled for that core, pending and not already taken, and marks that source as owned by the core. From then on the source is hidden from every core until the owner completes it. A core that claims after another core has taken the shared source gets the next candidate, or the all-ones "none" code when nothing is left. Same-cycle claims are resolved in favour of the lower-numbered core.

Software interrupts give cores a way to signal each other. Writing a target core number to the software-interrupt register makes one extra source pending. That source sits at ID `NUM_SRC + target`, always uses the normal line, and is enabled only for the target core. Completing its claim clears it.

Top module: `irq_router`

## Requirements
- R1: After reset every enable, class bit, claim and software interrupt is clear, both lines of every core are low, and a claim returns the none code (all ones, 0x3FF for a 10-bit ID).
- R2: A configuration write with `cfg_sel`=0 sets the per-core enable mask of source `cfg_idx` to `cfg_wdata` (bit k = core k). A pending source whose mask bit for a core is 0 never raises that core's lines and is never returned to it.
- R3: A configuration write with `cfg_sel`=1 sets the class of source `cfg_idx` from `cfg_wdata[0]`: 1 routes it to the fast line, 0 to the normal line.
- R4: A claim strobe on core k in one cycle gives `claim_vld[k]`=1 and the claim result in the next cycle. The result is the lowest-numbered ID that is enabled for k, pending and unclaimed, or the none code.
- R5: A claimed ID is hidden from all cores. Other cores' claims return the next eligible ID or the none code, and lines held up only by that ID fall.
- R6: When several cores claim in the same cycle, lower-numbered cores pick first, so two valid results from that cycle are never the same ID.
- R7: A completion from the owning core, carrying the claimed ID, releases the claim. A source whose input is still high can then be claimed again.
- R8: A completion carrying an ID that the core does not own is ignored, and the claim stays in force.
- R9: A configuration write with `cfg_sel`=2 and `cfg_idx`=t makes ID `NUM_SRC+t` pending. It is seen only by core t, drives only its normal line, and is cleared by its completion.
- R10: The lines are registered. After an input edge they change at the next clock edge. After a configuration write, claim or completion they change at the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Level-sensitive hardware interrupt inputs |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable mask, 1 class, 2 software interrupt |
| cfg_idx | input | clog2(NUM_SRC) | Source number, or target core for software interrupts |
| cfg_wdata | input | NUM_CORE | Write data |
| claim_rd | input | NUM_CORE | Per-core claim strobe |
| claim_vld | output | NUM_CORE | Per-core claim result valid |
| claim_id | output | NUM_CORE*10 | Per-core claimed ID, core k in bits [10k+9:10k] |
| cmpl_wr | input | NUM_CORE | Per-core completion strobe |
| cmpl_id | input | NUM_CORE*10 | Per-core completed ID, same packing as claim_id |
| irq | output | NUM_CORE | Per-core normal interrupt line |
| fiq | output | NUM_CORE | Per-core fast interrupt line |

## Verification
An input edge shows on the lines one clock later. A configuration write, claim or completion is registered at one edge and reaches the lines at the following edge. A claim result is registered at the edge that takes the strobe. The bench drives every stimulus on a falling edge and samples on falling edges. For a result that is one edge late it waits one falling edge. For a result that is two edges late it first checks that the line has not yet moved and then checks it one falling edge later. Same-cycle claims from both cores share one strobe cycle, so the tie-break is exercised exactly.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int ID_W = 10;
   localparam logic [ID_W-1:0] ID_NONE = '1;

   typedef enum logic [1:0] {
      CFG_ENABLE = 2'd0,
      CFG_CLASS  = 2'd1,
      CFG_SWI    = 2'd2
   } cfg_sel_e;
endpackage

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest
   import irq_router_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]    vec,
   output logic            found,
   output logic [ID_W-1:0] idx,
   output logic [W-1:0]    onehot
);
   always_comb begin
      idx = ID_NONE;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = ID_W'(i);
      end
   end

   assign found  = |vec;
   assign onehot = vec & (~vec + W'(1));
endmodule

// File: rtl/irq_claim_table.sv
module irq_claim_table
   import irq_router_pkg::*;
#(
   parameter int NUM_ID   = 18,
   parameter int NUM_CORE = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_CORE*NUM_ID-1:0] grant,
   input  logic [NUM_CORE-1:0]      cmpl_wr,
   input  logic [NUM_CORE*ID_W-1:0] cmpl_id,
   output logic [NUM_ID-1:0]        claimed,
   output logic [NUM_ID-1:0]        released
);
   localparam int OWN_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

   logic [NUM_ID-1:0] claimed_q;
   logic [NUM_ID-1:0] take;
   logic [OWN_W-1:0]  owner_q   [NUM_ID];
   logic [OWN_W-1:0]  owner_new [NUM_ID];

   always_comb begin
      for (int i = 0; i < NUM_ID; i++) begin
         take[i]      = 1'b0;
         owner_new[i] = '0;
         released[i]  = 1'b0;
         for (int k = 0; k < NUM_CORE; k++) begin
            if (grant[k*NUM_ID + i]) begin
               take[i]      = 1'b1;
               owner_new[i] = OWN_W'(k);
            end
            if (cmpl_wr[k] && claimed_q[i] &&
                cmpl_id[k*ID_W +: ID_W] == ID_W'(i) &&
                owner_q[i] == OWN_W'(k))
               released[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_ID; i++) begin
         if (rst) begin
            claimed_q[i] <= 1'b0;
            owner_q[i]   <= '0;
         end else if (take[i]) begin
            claimed_q[i] <= 1'b1;
            owner_q[i]   <= owner_new[i];
         end else if (released[i]) begin
            claimed_q[i] <= 1'b0;
         end
      end
   end

   assign claimed = claimed_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_SRC  = 16,
   parameter int NUM_CORE = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_SRC-1:0]           src_in,
   input  logic                         cfg_wr,
   input  logic [1:0]                   cfg_sel,
   input  logic [$clog2(NUM_SRC)-1:0]   cfg_idx,
   input  logic [NUM_CORE-1:0]          cfg_wdata,
   input  logic [NUM_CORE-1:0]          claim_rd,
   output logic [NUM_CORE-1:0]          claim_vld,
   output logic [NUM_CORE*ID_W-1:0]     claim_id,
   input  logic [NUM_CORE-1:0]          cmpl_wr,
   input  logic [NUM_CORE*ID_W-1:0]     cmpl_id,
   output logic [NUM_CORE-1:0]          irq,
   output logic [NUM_CORE-1:0]          fiq
);
   localparam int NUM_ID = NUM_SRC + NUM_CORE;
   localparam int SRC_W  = $clog2(NUM_SRC);

   if (NUM_SRC < 2) begin : g_chk_src
      $error("irq_router: NUM_SRC must be at least 2");
   end
   if (NUM_CORE < 1 || NUM_CORE > NUM_SRC) begin : g_chk_core
      $error("irq_router: NUM_CORE must be 1..NUM_SRC");
   end
   if (NUM_ID >= (1 << ID_W) - 1) begin : g_chk_id
      $error("irq_router: ID space leaves no room for the none code");
   end

   cfg_sel_e cfg_sel_e_w;
   assign cfg_sel_e_w = cfg_sel_e'(cfg_sel);

   logic [NUM_CORE-1:0] en_q [NUM_SRC];
   logic [NUM_SRC-1:0]  class_fiq_q;
   logic [NUM_CORE-1:0] swi_q;

   logic [NUM_ID-1:0]          claimed, released, fiq_mask;
   logic [NUM_CORE*NUM_ID-1:0] grant;
   logic [NUM_ID-1:0]          taken [NUM_CORE+1];

   assign fiq_mask = {{NUM_CORE{1'b0}}, class_fiq_q};
   assign taken[0] = '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_SRC; i++) en_q[i] <= '0;
         class_fiq_q <= '0;
         swi_q       <= '0;
      end else begin
         for (int j = 0; j < NUM_CORE; j++) begin
            if (released[NUM_SRC + j]) swi_q[j] <= 1'b0;
         end
         if (cfg_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (cfg_idx == SRC_W'(i)) begin
                  if (cfg_sel_e_w == CFG_ENABLE) en_q[i] <= cfg_wdata;
                  if (cfg_sel_e_w == CFG_CLASS)  class_fiq_q[i] <= cfg_wdata[0];
               end
            end
            for (int j = 0; j < NUM_CORE; j++) begin
               if (cfg_sel_e_w == CFG_SWI && cfg_idx == SRC_W'(j))
                  swi_q[j] <= 1'b1;
            end
         end
      end
   end

   for (genvar k = 0; k < NUM_CORE; k++) begin : g_core
      logic [NUM_ID-1:0] elig, avail, pick_oh;
      logic              found;
      logic [ID_W-1:0]   pick_idx, claim_q;
      logic              vld_q, irq_q, fiq_q;

      always_comb begin
         for (int i = 0; i < NUM_SRC; i++) elig[i] = src_in[i] & en_q[i][k];
         for (int j = 0; j < NUM_CORE; j++) elig[NUM_SRC + j] = swi_q[j] && (j == k);
         elig = elig & ~claimed;
      end

      assign avail = elig & ~taken[k];

      irq_pick_lowest #(.W(NUM_ID)) u_pick (
         .vec    (avail),
         .found  (found),
         .idx    (pick_idx),
         .onehot (pick_oh)
      );

      assign grant[k*NUM_ID +: NUM_ID] = claim_rd[k] ? pick_oh : '0;
      assign taken[k+1] = taken[k] | grant[k*NUM_ID +: NUM_ID];

      always_ff @(posedge clk) begin
         if (rst) begin
            claim_q <= ID_NONE;
            vld_q   <= 1'b0;
            irq_q   <= 1'b0;
            fiq_q   <= 1'b0;
         end else begin
            vld_q <= claim_rd[k];
            if (claim_rd[k]) claim_q <= found ? pick_idx : ID_NONE;
            irq_q <= |(elig & ~fiq_mask);
            fiq_q <= |(elig & fiq_mask);
         end
      end

      assign claim_id[k*ID_W +: ID_W] = claim_q;
      assign claim_vld[k] = vld_q;
      assign irq[k]       = irq_q;
      assign fiq[k]       = fiq_q;
   end

   irq_claim_table #(.NUM_ID(NUM_ID), .NUM_CORE(NUM_CORE)) u_table (
      .clk      (clk),
      .rst      (rst),
      .grant    (grant),
      .cmpl_wr  (cmpl_wr),
      .cmpl_id  (cmpl_id),
      .claimed  (claimed),
      .released (released)
   );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_router_pkg::*;
#(
   parameter int NUM_SRC  = 16,
   parameter int NUM_CORE = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic [NUM_CORE-1:0]      claim_rd,
   input logic [NUM_CORE-1:0]      claim_vld,
   input logic [NUM_CORE*ID_W-1:0] claim_id,
   input logic [NUM_CORE-1:0]      irq,
   input logic [NUM_CORE-1:0]      fiq
);
   localparam int NUM_ID = NUM_SRC + NUM_CORE;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $past(rst) |-> (irq == '0 && fiq == '0 && claim_vld == '0));

   for (genvar k = 0; k < NUM_CORE; k++) begin : g_k
      assert_vld_follows_rd_R4: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> claim_vld[k] == $past(claim_rd[k]));

      assert_id_in_range_R4: assert property (@(posedge clk) disable iff (rst)
         (claim_vld[k] && claim_id[k*ID_W +: ID_W] != ID_NONE)
            |-> int'(claim_id[k*ID_W +: ID_W]) < NUM_ID);

      for (genvar m = k + 1; m < NUM_CORE; m++) begin : g_m
         assert_distinct_claims_R6: assert property (@(posedge clk) disable iff (rst)
            (claim_vld[k] && claim_vld[m] && claim_id[k*ID_W +: ID_W] != ID_NONE)
               |-> claim_id[k*ID_W +: ID_W] != claim_id[m*ID_W +: ID_W]);
      end
   end
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .claim_rd  (claim_rd),
   .claim_vld (claim_vld),
   .claim_id  (claim_id),
   .irq       (irq),
   .fiq       (fiq)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NS   = 16;
   localparam int NC   = 2;
   localparam int IDW  = 10;
   localparam int NONE = 1023;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NS-1:0]     src_in = '0;
   logic              cfg_wr = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [3:0]        cfg_idx = '0;
   logic [NC-1:0]     cfg_wdata = '0;
   logic [NC-1:0]     claim_rd = '0;
   logic [NC-1:0]     claim_vld;
   logic [NC*IDW-1:0] claim_id;
   logic [NC-1:0]     cmpl_wr = '0;
   logic [NC*IDW-1:0] cmpl_id = '0;
   logic [NC-1:0]     irq, fiq;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_router #(.NUM_SRC(NS), .NUM_CORE(NC)) u_irq_router (
      .clk(clk), .rst(rst), .src_in(src_in), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .claim_rd(claim_rd),
      .claim_vld(claim_vld), .claim_id(claim_id), .cmpl_wr(cmpl_wr),
      .cmpl_id(cmpl_id), .irq(irq), .fiq(fiq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic cfg_write(input int sel, input int idx, input int data);
      cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_idx = 4'(idx); cfg_wdata = NC'(data);
      step();
      cfg_wr = 1'b0;
   endtask

   task automatic claim(input int k, input int exp, input string req);
      claim_rd[k] = 1'b1;
      step();
      claim_rd = '0;
      check(claim_vld[k] == 1'b1, req, int'(claim_vld[k]), 1);
      check(int'(claim_id[k*IDW +: IDW]) == exp, req, int'(claim_id[k*IDW +: IDW]), exp);
   endtask

   task automatic complete(input int k, input int id);
      cmpl_wr[k] = 1'b1; cmpl_id[k*IDW +: IDW] = IDW'(id);
      step();
      cmpl_wr = '0;
   endtask

   task automatic t_reset();
      check(irq == '0 && fiq == '0, "R1", int'({fiq, irq}), 0);
      claim(0, NONE, "R1");
   endtask

   task automatic t_enable();
      src_in[3] = 1'b1; src_in[5] = 1'b1;
      step();
      check(irq == '0, "R2", int'(irq), 0);
      cfg_write(0, 3, 1);
      check(irq == '0, "R10", int'(irq), 0);
      step();
      check(irq == 2'b01, "R2", int'(irq), 1);
   endtask

   task automatic t_class();
      cfg_write(1, 3, 1);
      step();
      check(fiq == 2'b01 && irq == '0, "R3", int'({fiq, irq}), 4);
      cfg_write(1, 3, 0);
      step();
      check(fiq == '0 && irq == 2'b01, "R3", int'({fiq, irq}), 1);
   endtask

   task automatic t_share();
      cfg_write(0, 3, 3);
      cfg_write(0, 7, 3);
      src_in[7] = 1'b1;
      step();
      check(irq == 2'b11, "R2", int'(irq), 3);
      claim(1, 3, "R4");
      claim(0, 7, "R5");
      claim(1, NONE, "R5");
      step();
      check(irq == '0, "R5", int'(irq), 0);
   endtask

   task automatic t_complete();
      complete(0, 3);
      claim(0, NONE, "R8");
      complete(1, 3);
      claim(0, 3, "R7");
      complete(0, 3);
      complete(0, 7);
      step();
      check(irq == 2'b11, "R7", int'(irq), 3);
   endtask

   task automatic t_tie();
      claim_rd = 2'b11;
      step();
      claim_rd = '0;
      check(int'(claim_id[0 +: IDW]) == 3, "R6", int'(claim_id[0 +: IDW]), 3);
      check(int'(claim_id[IDW +: IDW]) == 7, "R6", int'(claim_id[IDW +: IDW]), 7);
      complete(0, 3);
      complete(1, 7);
      src_in = '0;
      step();
      step();
      check(irq == '0, "R10", int'(irq), 0);
   endtask

   task automatic t_swi();
      cfg_write(2, 1, 0);
      check(irq == '0, "R10", int'(irq), 0);
      step();
      check(irq == 2'b10, "R9", int'(irq), 2);
      claim(0, NONE, "R9");
      claim(1, NS + 1, "R9");
      complete(1, NS + 1);
      step();
      check(irq == '0, "R9", int'(irq), 0);
      claim(1, NONE, "R9");
   endtask

   initial begin
      repeat (3) step();
      rst = 1'b0;
      step();
      t_reset();
      t_enable();
      t_class();
      t_share();
      t_complete();
      t_tie();
      t_swi();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule